// File: doc/BRIEF.md
# Inverting Registered Bus Transceiver

This block passes an eight-bit word between an A side and a B side. Each direction has its own storage bank and its own three active-low controls: a chip enable, a latch enable and an output enable. A word that crosses the block always comes out as its bitwise complement. Each bank can either follow its source side live, or hold a captured value while the source side changes.

The latches are modelled as registers on a system clock. While a bank is transparent, its register reloads on every clock and the output takes the live input through a combinational bypass. Transparent traffic therefore has no cycle of latency. When latch enable returns high, the bank keeps the word it sampled at the last clock edge at which the latch was still open. The two bus sides are not real three-state pins. Each side is split into an input vector, an output vector and a one-bit drive enable. The output vector carries no meaning while its enable is low. A contention flag rises whenever both directions would drive at the same moment.

The control rules of one direction are the same for the other. The A-to-B bank uses `ab_cs_n`, `ab_open_n` and `ab_drv_n`, reads `a_in` and drives the B side. The B-to-A bank uses `ba_cs_n`, `ba_open_n` and `ba_drv_n`, reads `b_in` and drives the A side.

Top module: `inv_reg_xcvr`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising clock edge) clears both banks to zero. A bank that is then read in hold mode drives 8'hFF, the complement of zero.
- R2: While a direction's chip enable and latch enable are both low, its bank is transparent. When that direction also drives, its destination output equals the bitwise complement of the live source input in the same cycle.
- R3: With chip enable low, the bank stores the source value present at the last rising clock edge where latch enable was still low. While latch enable then stays high, the driven output is the complement of that stored word, and later source changes have no effect.
- R4: While a direction's chip enable is high, its bank does not load, whatever its latch enable is, and its destination drive enable is low. When the bank is opened for reading again, it still shows the word it held before.
- R5: A destination drive enable (`b_oe` for A-to-B, `a_oe` for B-to-A) is high exactly when that direction's chip enable and output enable are both low. Output enable high forces the drive enable low.
- R6: The B-to-A bank follows R2 to R5 with its own controls. Activity in one direction neither loads nor disturbs the storage of the other.
- R7: `contention` is high exactly when `a_oe` and `b_oe` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that times the latch registers |
| rst_n | input | 1 | Synchronous active-low reset; clears both banks |
| ab_cs_n | input | 1 | A-to-B chip enable, active low |
| ab_open_n | input | 1 | A-to-B latch enable, active low (low = transparent) |
| ab_drv_n | input | 1 | A-to-B output enable, active low |
| ba_cs_n | input | 1 | B-to-A chip enable, active low |
| ba_open_n | input | 1 | B-to-A latch enable, active low (low = transparent) |
| ba_drv_n | input | 1 | B-to-A output enable, active low |
| a_in | input | 8 | Value seen on the A side |
| a_out | output | 8 | Value driven onto the A side (complement of the B-to-A path) |
| a_oe | output | 1 | Drive enable for the A side |
| b_in | input | 8 | Value seen on the B side |
| b_out | output | 8 | Value driven onto the B side (complement of the A-to-B path) |
| b_oe | output | 1 | Drive enable for the B side |
| contention | output | 1 | Both sides are driven at the same time |

## Verification
The bench goes after five cases:

- **Capture edge.** The source changes in the cycle after latch enable rises. A design that captured one clock late would show the new word instead of the held one.
- **Chip enable high with latch enable low.** This must not load. A design that let latch enable alone open the bank would pick up the word presented while deselected and show it when the bank is read again.
- **Reset value.** A design that left out the inversion or the reset would read back 8'h00 or a stale word after reset, not 8'hFF.
- **Directions used at different times.** Random and directed sequences operate one direction while the other holds. Crossed control wiring, or a bank shared between the directions, would corrupt the idle bank.
- **Contention flag.** The flag is checked against both drive enables in every cycle.

// File: rtl/xcvr_pkg.sv
// Package: xcvr_pkg
// Shared types for the inverting registered transceiver.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xcvr_pkg;

    // Operating state of one direction's latch bank.
    typedef enum logic [1:0] {
        BANK_OFF  = 2'd0,   // deselected: no load, no drive
        BANK_HOLD = 2'd1,   // selected, latch closed: stored word kept
        BANK_PASS = 2'd2    // selected, latch open: follows source live
    } bank_mode_e;

    // Number of transfer directions (A-to-B and B-to-A).
    localparam int unsigned NUM_DIRS = 2;

endpackage

// File: rtl/xcvr_ctrl.sv
// Module: xcvr_ctrl
// Decodes the three active-low controls of one direction into a bank
// mode, a load strobe and a drive enable.
// Assumes: controls are synchronous to clk; chip enable dominates the
// latch enable for loading, and gates the output enable for driving.
module xcvr_ctrl
    import xcvr_pkg::*;
(
    input  logic       cs_n,
    input  logic       open_n,
    input  logic       drv_n,
    output bank_mode_e mode,
    output logic       load,
    output logic       drive
);

    // Mode decode: chip enable first, then latch enable.
    always_comb begin
        if (cs_n) begin
            mode = BANK_OFF;
        end else if (!open_n) begin
            mode = BANK_PASS;
        end else begin
            mode = BANK_HOLD;
        end
    end

    // Load only while transparent; drive needs both enables low.
    always_comb begin
        load  = (mode == BANK_PASS);
        drive = (mode != BANK_OFF) && !drv_n;
    end

endmodule

// File: rtl/xcvr_store.sv
// Module: xcvr_store
// Storage register of one latch bank. It reloads from its source on
// every clock while load is high, and holds otherwise.
// Assumes: synchronous active-low reset, which clears the word to zero.
module xcvr_store #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture or hold the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_bank.sv
// Module: xcvr_bank
// One direction of the transceiver: control decode, storage, a
// transparent bypass and an inverting output stage.
// Assumes: the output value is meaningful only while oe is high.
module xcvr_bank
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             open_n,
    input  logic             drv_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst,
    output logic             oe
);

    bank_mode_e       mode;
    logic             load;
    logic             drive;
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] latch_val;

    xcvr_ctrl u_ctrl (
        .cs_n   (cs_n),
        .open_n (open_n),
        .drv_n  (drv_n),
        .mode   (mode),
        .load   (load),
        .drive  (drive)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (src),
        .q     (held)
    );

    // Latch output: the live source while transparent, the stored word otherwise.
    always_comb begin
        latch_val = (mode == BANK_PASS) ? src : held;
    end

    // Inverting output stage with its drive enable.
    always_comb begin
        dst = ~latch_val;
        oe  = drive;
    end

endmodule

// File: rtl/inv_reg_xcvr.sv
// Module: inv_reg_xcvr
// Top level of the octal inverting registered transceiver. It holds two
// independent banks, one per direction, and flags contention whenever
// both sides are driven at once.
// Assumes: the bus sides are split into in/out/enable vectors; no real
// three-state pins; synchronous active-low reset.
module inv_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ab_cs_n,
    input  logic             ab_open_n,
    input  logic             ab_drv_n,
    input  logic             ba_cs_n,
    input  logic             ba_open_n,
    input  logic             ba_drv_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             contention
);

    // Index 0 is A-to-B, index 1 is B-to-A.
    logic [NUM_DIRS-1:0]             cs_n_v;
    logic [NUM_DIRS-1:0]             open_n_v;
    logic [NUM_DIRS-1:0]             drv_n_v;
    logic [NUM_DIRS-1:0]             oe_v;
    logic [NUM_DIRS-1:0][WIDTH-1:0]  src_v;
    logic [NUM_DIRS-1:0][WIDTH-1:0]  dst_v;

    // Gather the per-direction controls and sources into vectors.
    always_comb begin
        cs_n_v   = {ba_cs_n,   ab_cs_n};
        open_n_v = {ba_open_n, ab_open_n};
        drv_n_v  = {ba_drv_n,  ab_drv_n};
        src_v[0] = a_in;
        src_v[1] = b_in;
    end

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        xcvr_bank #(.WIDTH(WIDTH)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .cs_n   (cs_n_v[g]),
            .open_n (open_n_v[g]),
            .drv_n  (drv_n_v[g]),
            .src    (src_v[g]),
            .dst    (dst_v[g]),
            .oe     (oe_v[g])
        );
    end

    // Route each bank to its destination side and flag a double drive.
    always_comb begin
        b_out      = dst_v[0];
        b_oe       = oe_v[0];
        a_out      = dst_v[1];
        a_oe       = oe_v[1];
        contention = &oe_v;
    end

endmodule

// File: rtl/xcvr_checker.sv
// Module: xcvr_checker
// Protocol checker for inv_reg_xcvr. It sees only ports and is attached
// with bind.
// Assumes: the same clock and synchronous active-low reset as the top.
module xcvr_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ab_cs_n,
    input logic             ab_open_n,
    input logic             ab_drv_n,
    input logic             ba_cs_n,
    input logic             ba_open_n,
    input logic             ba_drv_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             contention
);

    AST_AB_PASS_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_cs_n && !ab_open_n && !ab_drv_n) |-> (b_out == ~a_in)); // R2

    AST_BA_PASS_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_cs_n && !ba_open_n && !ba_drv_n) |-> (a_out == ~b_in)); // R6

    AST_AB_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ab_cs_n && ab_open_n && !ab_drv_n)
         && !ab_cs_n && ab_open_n && !ab_drv_n) |-> $stable(b_out)); // R3

    AST_BA_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ba_cs_n && ba_open_n && !ba_drv_n)
         && !ba_cs_n && ba_open_n && !ba_drv_n) |-> $stable(a_out)); // R6

    AST_AB_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ab_cs_n |-> !b_oe); // R4

    AST_BA_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ba_cs_n |-> !a_oe); // R6

    AST_AB_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe == (!ab_cs_n && !ab_drv_n)); // R5

    AST_BA_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe == (!ba_cs_n && !ba_drv_n)); // R6

    AST_CONTENTION_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        contention == (a_oe && b_oe)); // R7

endmodule

bind inv_reg_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ab_cs_n    (ab_cs_n),
    .ab_open_n  (ab_open_n),
    .ab_drv_n   (ab_drv_n),
    .ba_cs_n    (ba_cs_n),
    .ba_open_n  (ba_open_n),
    .ba_drv_n   (ba_drv_n),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .contention (contention)
);

// File: tb/inv_reg_xcvr_bench.sv
// Bench for inv_reg_xcvr. Inputs are driven at the falling clock edge and
// outputs are sampled 2 ns later. A behavioural model of each bank is
// updated at the rising edge from the requirements.
module inv_reg_xcvr_bench;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_cs_n = 1'b1, ab_open_n = 1'b1, ab_drv_n = 1'b1;
    logic         ba_cs_n = 1'b1, ba_open_n = 1'b1, ba_drv_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe, contention;

    int unsigned  n_tests = 0;
    int unsigned  n_fail  = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit           done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    inv_reg_xcvr #(.WIDTH(W)) u_inv_reg_xcvr (
        .clk(clk), .rst_n(rst_n),
        .ab_cs_n(ab_cs_n), .ab_open_n(ab_open_n), .ab_drv_n(ab_drv_n),
        .ba_cs_n(ba_cs_n), .ba_open_n(ba_open_n), .ba_drv_n(ba_drv_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .contention(contention)
    );

    // Model of the banks: reset to zero; load only when selected and open.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab <= '0;
            m_ba <= '0;
        end else begin
            if (!ab_cs_n && !ab_open_n) m_ab <= a_in;
            if (!ba_cs_n && !ba_open_n) m_ba <= b_in;
        end
    end

    function automatic logic [W-1:0] exp_out(input logic cs_n, input logic open_n,
                                             input logic [W-1:0] src,
                                             input logic [W-1:0] st);
        return (!cs_n && !open_n) ? ~src : ~st;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model; data only where driven.
    task automatic check_all(input string tag_ab, input string tag_ba);
        logic eb, ea;
        eb = !ab_cs_n && !ab_drv_n;
        ea = !ba_cs_n && !ba_drv_n;
        check("R5 b_oe", {7'd0, b_oe}, {7'd0, eb});
        check("R6 a_oe", {7'd0, a_oe}, {7'd0, ea});
        check("R7 contention", {7'd0, contention}, {7'd0, ea && eb});
        if (eb) check(tag_ab, b_out, exp_out(ab_cs_n, ab_open_n, a_in, m_ab));
        if (ea) check(tag_ba, a_out, exp_out(ba_cs_n, ba_open_n, b_in, m_ba));
    endtask

    task automatic drive(input logic [2:0] ab, input logic [2:0] ba,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        {ab_cs_n, ab_open_n, ab_drv_n} = ab;
        {ba_cs_n, ba_open_n, ba_drv_n} = ba;
        a_in = a;
        b_in = b;
        #2;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: both banks read back the complement of zero after reset.
        drive(3'b010, 3'b010, 8'h5A, 8'hA5);
        check("R1 b_out after reset", b_out, 8'hFF);
        check("R1 a_out after reset", a_out, 8'hFF);
        check_all("R1", "R1");

        // R2: transparent A-to-B follows the live input, inverted.
        drive(3'b000, 3'b111, 8'h3C, 8'h00);
        check("R2 transparent", b_out, 8'hC3);
        drive(3'b000, 3'b111, 8'h81, 8'h00);
        check("R2 transparent follow", b_out, 8'h7E);

        // R3: close the latch, then change the input; the held word stays.
        drive(3'b010, 3'b111, 8'h81, 8'h00);
        check("R3 captured", b_out, 8'h7E);
        drive(3'b010, 3'b111, 8'hF0, 8'h00);
        check("R3 input ignored", b_out, 8'h7E);

        // R4: deselected with latch open: no drive and no load.
        drive(3'b100, 3'b111, 8'h55, 8'h00);
        check("R4 no drive", {7'd0, b_oe}, 8'h00);
        drive(3'b100, 3'b111, 8'h66, 8'h00);
        drive(3'b010, 3'b111, 8'h99, 8'h00);
        check("R4 kept word", b_out, 8'h7E);

        // R6: operate B-to-A; the A-to-B storage must be untouched.
        drive(3'b011, 3'b000, 8'h00, 8'h12);
        check("R6 ba transparent", a_out, 8'hED);
        drive(3'b011, 3'b010, 8'h00, 8'hFF);
        check("R6 ba captured", a_out, 8'hED);
        drive(3'b010, 3'b011, 8'h00, 8'h34);
        check("R6 ab undisturbed", b_out, 8'h7E);

        // R5: output enable high forces the drive enable low.
        drive(3'b001, 3'b001, 8'h00, 8'h00);
        check("R5 b_oe off", {7'd0, b_oe}, 8'h00);
        check("R5 a_oe off", {7'd0, a_oe}, 8'h00);

        // R7: both directions driving raises contention.
        drive(3'b010, 3'b010, 8'h00, 8'h00);
        check("R7 contention on", {7'd0, contention}, 8'h01);

        // Random mix with a bias toward selected, driving banks.
        for (int i = 0; i < 600; i++) begin
            logic [2:0] ab, ba;
            ab = {($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0};
            ba = {($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 3) == 0};
            drive(ab, ba, W'($urandom), W'($urandom));
            check_all("R3 ab data", "R6 ba data");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule